// File: doc/BRIEF.md
# Card Host Interrupt and Command-Start Controller

This block is the register-side control logic of a memory-card host controller. It collects interrupt events from the card-side command and data paths into a 17-bit sticky raw status register. A mask register selects which sources may interrupt, a masked status view exposes the enabled pending sources, and a global enable gates the single interrupt line to the processor. Software clears status bits by writing ones to them.

The block also owns the command register and its start bit. Software writes a command word with the start bit set. The block then presents the word to the card-side command unit on a valid/ready handshake. The start bit stays set, and the word stays frozen, until the command unit accepts it. Any command-register write made while a command is still pending is dropped and raises the hardware-lock error source. The command unit may apply back-pressure for any number of cycles by holding `cmd_ready` low. A command that only updates the card clock settings is handed over like any other command, but its completion never raises the command-done source.

Top module: `mci_irq_cmd_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `cmd_valid` is 0. The register addresses are: control 0x00 (global enable at bit 4), mask 0x04, command 0x08, masked status 0x0C and raw status 0x10.
- R2: A one-cycle pulse on `src_evt[k]` sets raw status bit k, and the bit stays set. This holds for every k except 2 and 12. Pulses on `src_evt[2]` (command done) and `src_evt[12]` (hardware lock) are ignored.
- R3: Writing the raw status register clears each bit whose write-data bit is 1 and leaves bits written with 0 unchanged. If a source event and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: The masked status register reads as raw status AND mask, whatever the value of the global enable.
- R5: `irq` is 1 exactly when the global enable is 1 and at least one raw status bit whose mask bit is 1 is set.
- R6: When no command is pending, a command write with bit 31 (start) set stores the word. From the next cycle, `cmd_valid` is 1 and `cmd_word` equals the written word.
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid` and `cmd_word` hold. In the cycle after `cmd_valid` and `cmd_ready` are both 1, `cmd_valid` is 0 and the command register reads back with bit 31 cleared and bits [30:0] unchanged.
- R8: A command write made while the start bit is 1 does not change the command register and sets raw status bit 12.
- R9: A `cmd_done` pulse sets raw status bit 2, unless the last command handed over had bit 21 (clock update only) set. In that case the pulse has no effect.
- R10: A command write with both bit 24 and bit 26 (boot start and boot stop) set is discarded. The register is unchanged, no request is raised, and bit 12 is not set.
- R11: A command write with bit 31 clear, made while no command is pending, stores the word without raising `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_evt | input | 17 | Event pulses from the command and data paths |
| cmd_valid | output | 1 | Command offered to the card-side unit |
| cmd_ready | input | 1 | Card-side unit accepts the command |
| cmd_word | output | 32 | Command word being offered |
| cmd_done | input | 1 | Card-side unit reports command completion |
| irq | output | 1 | Interrupt to the processor |

## Verification
The status path is driven three ways: single-source pulses, a pulse on one of the two internally owned bits, and a clear that collides with a new event in the same cycle. Together these separate plain stickiness, input filtering and set-over-clear priority. Mask and global enable are toggled on their own, so the masked view is shown to ignore the enable while the interrupt line does not. The command path is tried with an accepted write held under back-pressure, a write collision during that wait, a clock-update-only command followed by a completion, a boot-conflicting write and a write without start. Each of these changes a different piece of state, so each tells apart a distinct failure.

// File: rtl/mci_ic_pkg.sv
package mci_ic_pkg;
  localparam int NUM_SRC  = 17;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;

  localparam int SRC_CMD_DONE = 2;
  localparam int SRC_HLOCK    = 12;
  localparam int CTRL_GIE_BIT = 4;

  localparam int CMD_START_BIT    = 31;
  localparam int CMD_CLKONLY_BIT  = 21;
  localparam int CMD_BOOT_ON_BIT  = 24;
  localparam int CMD_BOOT_OFF_BIT = 26;

  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] A_MASK  = 8'h04;
  localparam logic [ADDR_W-1:0] A_CMD   = 8'h08;
  localparam logic [ADDR_W-1:0] A_MSTAT = 8'h0C;
  localparam logic [ADDR_W-1:0] A_RSTAT = 8'h10;
endpackage

// File: rtl/mci_ic_status.sv
module mci_ic_status #(
  parameter int NUM_SRC      = 17,
  parameter int CMD_DONE_BIT = 2,
  parameter int HLOCK_BIT    = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic               gie_wdata,
  input  logic               mask_we,
  input  logic               rstat_we,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               lock_evt,
  input  logic               done_evt,
  output logic [NUM_SRC-1:0] raw_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               gie_o,
  output logic               irq_o
);
  localparam logic [NUM_SRC-1:0] OWNED =
    (NUM_SRC'(1) << CMD_DONE_BIT) | (NUM_SRC'(1) << HLOCK_BIT);

  logic [NUM_SRC-1:0] raw_q, mask_q, ext_evt, set_vec, clr_vec;
  logic               gie_q;

  always_comb begin
    ext_evt = src_evt & ~OWNED;
    set_vec = ext_evt;
    set_vec[HLOCK_BIT]    = lock_evt;
    set_vec[CMD_DONE_BIT] = done_evt;
    clr_vec = rstat_we ? wdata : '0;
  end

  // one sticky cell per source; a new event beats a clear
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          raw_q[i] <= 1'b0;
      else if (set_vec[i]) raw_q[i] <= 1'b1;
      else if (clr_vec[i]) raw_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= wdata;
      if (ctrl_we) gie_q  <= gie_wdata;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign gie_o  = gie_q;
  assign irq_o  = gie_q & (|(raw_q & mask_q));

  assert_ext_evt_sets_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_evt) |=> ((raw_q & $past(ext_evt)) == $past(ext_evt)));

  assert_owned_inputs_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_evt & OWNED) != '0 && !lock_evt && !done_evt && !rstat_we)
      |=> $stable(raw_q & OWNED));

  assert_w1c_only_written_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rstat_we && set_vec == '0) |=> (raw_q == ($past(raw_q) & ~$past(wdata))));

  assert_lock_sets_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |=> raw_q[HLOCK_BIT]);

  assert_no_irq_without_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq_o);
endmodule

// File: rtl/mci_ic_cmd.sv
module mci_ic_cmd #(
  parameter int DATA_W       = 32,
  parameter int START_BIT    = 31,
  parameter int CLKONLY_BIT  = 21,
  parameter int BOOT_ON_BIT  = 24,
  parameter int BOOT_OFF_BIT = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [DATA_W-1:0] cmd_word_o,
  input  logic              cmd_done_i,
  output logic              lock_evt_o,
  output logic              done_evt_o
);
  logic [DATA_W-1:0] word_q;
  logic              start_q, clk_only_q;
  logic              conflict, accept_wr, handoff;

  assign conflict  = wdata[BOOT_ON_BIT] & wdata[BOOT_OFF_BIT];
  assign accept_wr = cmd_we & ~start_q & ~conflict;
  assign handoff   = start_q & cmd_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q     <= '0;
      start_q    <= 1'b0;
      clk_only_q <= 1'b0;
    end else begin
      if (accept_wr) begin
        word_q  <= wdata;
        start_q <= wdata[START_BIT];
      end else if (handoff) begin
        start_q    <= 1'b0;
        clk_only_q <= word_q[CLKONLY_BIT];
      end
    end
  end

  always_comb begin
    cmd_word_o            = word_q;
    cmd_word_o[START_BIT] = start_q;
  end

  assign cmd_valid_o = start_q;
  assign lock_evt_o  = cmd_we & start_q;
  assign done_evt_o  = cmd_done_i & ~clk_only_q;

  assert_hold_under_backpressure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_word_o)));

  assert_start_clears_after_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_ready_i) |=> !cmd_valid_o);

  assert_pending_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_valid_o) |=> (cmd_word_o[START_BIT-1:0] == $past(cmd_word_o[START_BIT-1:0])));

  assert_boot_conflict_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && conflict && !cmd_valid_o) |=> (!cmd_valid_o && $stable(cmd_word_o)));
endmodule

// File: rtl/mci_irq_cmd_ctrl.sv
module mci_irq_cmd_ctrl
  import mci_ic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_we,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_evt,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [DATA_W-1:0]  cmd_word,
  input  logic               cmd_done,
  output logic               irq
);
  logic               ctrl_we, mask_we, rstat_we, cmd_we;
  logic               lock_evt, done_evt, gie;
  logic [NUM_SRC-1:0] raw, mask;

  assign ctrl_we  = bus_we && bus_addr == A_CTRL;
  assign mask_we  = bus_we && bus_addr == A_MASK;
  assign cmd_we   = bus_we && bus_addr == A_CMD;
  assign rstat_we = bus_we && bus_addr == A_RSTAT;

  mci_ic_status #(
    .NUM_SRC(NUM_SRC), .CMD_DONE_BIT(SRC_CMD_DONE), .HLOCK_BIT(SRC_HLOCK)
  ) u_status (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .gie_wdata(bus_wdata[CTRL_GIE_BIT]),
    .mask_we(mask_we), .rstat_we(rstat_we),
    .wdata(bus_wdata[NUM_SRC-1:0]),
    .src_evt(src_evt), .lock_evt(lock_evt), .done_evt(done_evt),
    .raw_o(raw), .mask_o(mask), .gie_o(gie), .irq_o(irq)
  );

  mci_ic_cmd #(
    .DATA_W(DATA_W), .START_BIT(CMD_START_BIT), .CLKONLY_BIT(CMD_CLKONLY_BIT),
    .BOOT_ON_BIT(CMD_BOOT_ON_BIT), .BOOT_OFF_BIT(CMD_BOOT_OFF_BIT)
  ) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(cmd_we), .wdata(bus_wdata),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_word_o(cmd_word), .cmd_done_i(cmd_done),
    .lock_evt_o(lock_evt), .done_evt_o(done_evt)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[CTRL_GIE_BIT] = gie;
      A_MASK:  bus_rdata[NUM_SRC-1:0]  = mask;
      A_CMD:   bus_rdata               = cmd_word;
      A_MSTAT: bus_rdata[NUM_SRC-1:0]  = raw & mask;
      A_RSTAT: bus_rdata[NUM_SRC-1:0]  = raw;
      default: bus_rdata = '0;
    endcase
  end

  assert_masked_irq_needs_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw & mask) != '0));
endmodule

// File: tb/mci_irq_cmd_ctrl_tb_top.sv
module mci_irq_cmd_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [16:0] src_evt = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [31:0] cmd_word;
  logic        cmd_done = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mci_irq_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .src_evt(src_evt),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .cmd_done(cmd_done), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [16:0] v);
    @(negedge clk); src_evt = v;
    @(negedge clk); src_evt = '0;
  endtask

  task automatic handoff();
    @(negedge clk); cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    foreach (d[i]) d[i] = 1'b0;
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h04, d); chk("R1 mask", d, 0);
    rd(8'h08, d); chk("R1 cmd", d, 0);
    rd(8'h0C, d); chk("R1 mstat", d, 0);
    rd(8'h10, d); chk("R1 rstat", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 cmd_valid", {31'b0, cmd_valid}, 0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse_evt(17'h10021);
    rd(8'h10, d); chk("R2 sticky sources", d, 32'h10021);
    pulse_evt(17'h01004);
    rd(8'h10, d); chk("R2 owned bits ignored", d, 32'h10021);
  endtask

  task automatic t_mask_irq();
    logic [31:0] d;
    wr(8'h04, 32'h00020);
    rd(8'h0C, d); chk("R4 masked view without enable", d, 32'h20);
    chk("R5 irq off without enable", {31'b0, irq}, 0);
    wr(8'h00, 32'h10);
    chk("R5 irq on", {31'b0, irq}, 1);
    rd(8'h0C, d); chk("R4 masked view with enable", d, 32'h20);
    wr(8'h04, 32'h00002);
    chk("R5 irq off when source masked", {31'b0, irq}, 0);
    wr(8'h04, 32'h00000);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(8'h10, 32'h00001);
    rd(8'h10, d); chk("R3 clear one bit", d, 32'h10020);
    wr(8'h10, 32'h00000);
    rd(8'h10, d); chk("R3 zero write no effect", d, 32'h10020);
    @(negedge clk);
    bus_addr = 8'h10; bus_wdata = 32'h00020; bus_we = 1'b1; src_evt = 17'h00020;
    @(negedge clk);
    bus_we = 1'b0; src_evt = '0;
    rd(8'h10, d); chk("R3 set wins over clear", d, 32'h10020);
    wr(8'h10, 32'h1FFFF);
    rd(8'h10, d); chk("R3 clear all", d, 0);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    wr(8'h08, 32'h8000_0011);
    chk("R6 valid raised", {31'b0, cmd_valid}, 1);
    chk("R6 word offered", cmd_word, 32'h8000_0011);
    rd(8'h08, d); chk("R6 start reads 1", d, 32'h8000_0011);
    repeat (3) @(negedge clk);
    chk("R7 valid held", {31'b0, cmd_valid}, 1);
    chk("R7 word held", cmd_word, 32'h8000_0011);
    wr(8'h08, 32'h8000_0022);
    chk("R8 word unchanged", cmd_word, 32'h8000_0011);
    rd(8'h10, d); chk("R8 lock error set", d, 32'h01000);
    handoff();
    chk("R7 valid dropped", {31'b0, cmd_valid}, 0);
    rd(8'h08, d); chk("R7 start self-cleared", d, 32'h0000_0011);
    wr(8'h10, 32'h1FFFF);
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
    rd(8'h10, d); chk("R9 command done set", d, 32'h00004);
  endtask

  task automatic t_clk_only();
    logic [31:0] d;
    wr(8'h10, 32'h1FFFF);
    wr(8'h08, 32'h8020_0000);
    chk("R6 clock-only offered", {31'b0, cmd_valid}, 1);
    handoff();
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
    rd(8'h10, d); chk("R9 no done for clock-only", d, 0);
  endtask

  task automatic t_boot_conflict();
    logic [31:0] d;
    wr(8'h08, 32'h8500_0001);
    chk("R10 no request", {31'b0, cmd_valid}, 0);
    rd(8'h08, d); chk("R10 register unchanged", d, 32'h0020_0000);
    rd(8'h10, d); chk("R10 no lock error", d, 0);
  endtask

  task automatic t_no_start();
    logic [31:0] d;
    wr(8'h08, 32'h0000_0033);
    @(negedge clk);
    chk("R11 no request", {31'b0, cmd_valid}, 0);
    rd(8'h08, d); chk("R11 word stored", d, 32'h0000_0033);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_events();
    t_mask_irq();
    t_w1c();
    t_cmd();
    t_clk_only();
    t_boot_conflict();
    t_no_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule